// File: doc/BRIEF.md
# Four-Channel DMA Register File

This block is the processor-facing register set of a four-channel DMA controller. A host with an 8-bit data bus reaches sixteen ports through a 4-bit offset, using a one-cycle synchronous write or read strobe. Each channel has a 16-bit address register and a 16-bit count register. Each of these is held as a base copy and a current copy. Because the bus is only one byte wide, both halves of a 16-bit register share a single port. A hidden byte pointer picks the low half or the high half, and software puts it in a known state by writing the clear-pointer port.

The other ports control the channels:
- a command register, which reads back as a status register;
- software request bits;
- mask bits, set one channel at a time or all four at once;
- per-channel mode fields;
- a master clear.

The transfer engine reads the mask bits, the modes and the register values from the output buses. The base and current copies are loaded together by a write. A read returns the current copy.

Top module: `dma_regfile`

## Requirements
- R1: After reset all four mask bits are 1, the byte pointer selects the low byte, and the command, request, mode and channel registers are all zero.
- R2: A write to offset 2n (address) or 2n+1 (count), n = 0..3, stores wdata into the byte chosen by the pointer (low when clear, high when set). It updates both the base and the current copy, then toggles the pointer.
- R3: While rd_en is high at offset 2n or 2n+1, rdata shows the pointer-selected byte of the current copy. At the clock edge the pointer toggles.
- R4: Any write to offset 0xC returns the pointer to the low byte.
- R5: A write to offset 0xA selects a channel with data bits [1:0]. It sets that channel's mask bit when bit 2 is 1 and clears it when bit 2 is 0.
- R6: A write to offset 0xB stores data bits [7:2] as the mode of the channel in bits [1:0]. Mode bit 2 (data bit 4) is auto-initialise, and mode bits [5:4] = 11 (data bits [7:6]) is cascade.
- R7: A write to offset 0x8 loads the command register. A read of 0x8 returns status, with the request bits in [7:4] and zeros in [3:0].
- R8: A write to offset 0x9 selects a channel with data bits [1:0]. It sets that channel's request bit when bit 2 is 1 and clears it when bit 2 is 0.
- R9: A write to offset 0xD (master clear) sets all mask bits, clears the pointer, the command register and the request bits, and leaves channel registers and modes unchanged.
- R10: A write to offset 0xE clears all mask bits. A write to offset 0xF loads the mask bits from data bits [3:0].
- R11: Reads of any offset from 0x9 to 0xF return 0x00 and leave the pointer unchanged. When rd_en is low, rdata is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe, one access per cycle |
| addr | input | 4 | Port offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| chan_mask | output | 4 | Mask bit per channel |
| chan_mode | output | 24 | Six-bit mode per channel, channel n in [6n+5:6n] |
| base_addr | output | 64 | Base address, channel n in [16n+15:16n] |
| cur_addr | output | 64 | Current address, same layout |
| base_cnt | output | 64 | Base count, same layout |
| cur_cnt | output | 64 | Current count, same layout |
| cmd_out | output | 8 | Command register |
| req_out | output | 4 | Software request bit per channel |

## Verification
The bench aims at the byte pointer: mixed reads and writes across channels, clears in the middle of a 16-bit pair, and master clear arriving with the pointer set. A design that toggled only on writes, or failed to share the pointer between channels, would put bytes into the wrong half. Channel-select decoding on the mask, request and mode ports is driven with every channel code and both polarities of bit 2, which exposes a design that writes the wrong channel or inverts the mask sense. Reads of the control ports are checked to return zero without moving the pointer, which catches a decoder that treats offsets 8 to 15 as channel registers.

// File: rtl/dma_regfile.sv
module dma_regfile (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [3:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic [3:0]  chan_mask,
  output logic [23:0] chan_mode,
  output logic [63:0] base_addr,
  output logic [63:0] cur_addr,
  output logic [63:0] base_cnt,
  output logic [63:0] cur_cnt,
  output logic [7:0]  cmd_out,
  output logic [3:0]  req_out
);
  localparam int NCH = 4;

  logic [15:0] ba [NCH];
  logic [15:0] ca [NCH];
  logic [15:0] bc [NCH];
  logic [15:0] cc [NCH];
  logic [5:0]  mode [NCH];
  logic        ptr;

  wire       is_ch = ~addr[3];
  wire [1:0] ch    = addr[2:1];
  wire [1:0] sel   = wdata[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr       <= 1'b0;
      chan_mask <= '1;
      cmd_out   <= '0;
      req_out   <= '0;
      for (int i = 0; i < NCH; i++) begin
        ba[i] <= '0; ca[i] <= '0; bc[i] <= '0; cc[i] <= '0; mode[i] <= '0;
      end
    end else begin
      if ((wr_en || rd_en) && is_ch) ptr <= ~ptr;
      if (wr_en) begin
        if (is_ch) begin
          if (!addr[0]) begin
            if (ptr) begin ba[ch][15:8] <= wdata; ca[ch][15:8] <= wdata; end
            else     begin ba[ch][7:0]  <= wdata; ca[ch][7:0]  <= wdata; end
          end else begin
            if (ptr) begin bc[ch][15:8] <= wdata; cc[ch][15:8] <= wdata; end
            else     begin bc[ch][7:0]  <= wdata; cc[ch][7:0]  <= wdata; end
          end
        end else begin
          case (addr[2:0])
            3'd0: cmd_out <= wdata;
            3'd1: req_out[sel] <= wdata[2];
            3'd2: chan_mask[sel] <= wdata[2];
            3'd3: mode[sel] <= wdata[7:2];
            3'd4: ptr <= 1'b0;
            3'd5: begin
              ptr       <= 1'b0;
              chan_mask <= '1;
              cmd_out   <= '0;
              req_out   <= '0;
            end
            3'd6: chan_mask <= '0;
            default: chan_mask <= wdata[3:0];
          endcase
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (is_ch) begin
        if (addr[0]) rdata = ptr ? cc[ch][15:8] : cc[ch][7:0];
        else         rdata = ptr ? ca[ch][15:8] : ca[ch][7:0];
      end else if (addr[2:0] == 3'd0) begin
        rdata = {req_out, 4'b0000};
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign chan_mode[6*g +: 6]  = mode[g];
    assign base_addr[16*g +: 16] = ba[g];
    assign cur_addr[16*g +: 16]  = ca[g];
    assign base_cnt[16*g +: 16]  = bc[g];
    assign cur_cnt[16*g +: 16]   = cc[g];
  end
endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [3:0] addr,
  input logic [7:0] wdata,
  input logic       ptr,
  input logic [3:0] chan_mask,
  input logic [7:0] cmd_out,
  input logic [3:0] req_out
);
  // R2
  ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && !addr[3]) |=> (ptr != $past(ptr)));
  // R4
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'hC) |=> !ptr);
  // R5
  single_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'hA) |=> (chan_mask[$past(wdata[1:0])] == $past(wdata[2])));
  // R9
  master_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'hD) |=> (chan_mask == 4'hF && cmd_out == 8'h00 && req_out == 4'h0 && !ptr));
  // R10
  clear_all_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'hE) |=> (chan_mask == 4'h0));
  // R11
  ctrl_read_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr[3]) |=> $stable(ptr));
endmodule

bind dma_regfile dma_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .ptr(ptr), .chan_mask(chan_mask), .cmd_out(cmd_out),
  .req_out(req_out)
);

// File: tb/tb_dma_regfile.sv
module tb_dma_regfile;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [3:0] chan_mask, req_out;
  logic [23:0] chan_mode;
  logic [63:0] base_addr, cur_addr, base_cnt, cur_cnt;
  logic [7:0] cmd_out;
  int checks = 0, fails = 0;
  bit done = 0;

  dma_regfile dut (.*);

  always #10 clk = ~clk;

  logic [15:0] m_adr [4];
  logic [15:0] m_cnt [4];
  logic [5:0]  m_mode [4];
  logic [3:0]  m_mask, m_req;
  logic [7:0]  m_cmd;
  bit          m_ptr;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(logic [3:0] a);
    case (a)
      4'h8: return "R7"; 4'h9: return "R8"; 4'hA: return "R5"; 4'hB: return "R6";
      4'hC: return "R4"; 4'hD: return "R9"; 4'hE, 4'hF: return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic cmp_outs(string tag);
    logic [23:0] md; logic [63:0] ad, cn;
    for (int i = 0; i < 4; i++) begin
      md[6*i +: 6] = m_mode[i]; ad[16*i +: 16] = m_adr[i]; cn[16*i +: 16] = m_cnt[i];
    end
    chk(tag, "mask", chan_mask, m_mask);
    chk(tag, "mode", chan_mode, md);
    chk(tag, "base_addr", base_addr, ad);
    chk(tag, "cur_addr", cur_addr, ad);
    chk(tag, "base_cnt", base_cnt, cn);
    chk(tag, "cur_cnt", cur_cnt, cn);
    chk(tag, "cmd", cmd_out, m_cmd);
    chk(tag, "req", req_out, m_req);
  endtask

  task automatic op(bit w, bit r, logic [3:0] a, logic [7:0] d);
    int c;
    logic [7:0] exp_rd;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    #1;
    exp_rd = 8'h00;
    if (r) begin
      if (a < 8) begin
        c = a[2:1];
        exp_rd = a[0] ? (m_ptr ? m_cnt[c][15:8] : m_cnt[c][7:0])
                      : (m_ptr ? m_adr[c][15:8] : m_adr[c][7:0]);
      end else if (a == 8) exp_rd = {m_req, 4'h0};
    end
    chk(r ? (a < 8 ? "R3" : (a == 8 ? "R7" : "R11")) : "R11", "rdata", rdata, exp_rd);
    if (w) begin
      c = d[1:0];
      if (a < 8) begin
        if (a[0]) begin if (m_ptr) m_cnt[a[2:1]][15:8] = d; else m_cnt[a[2:1]][7:0] = d; end
        else      begin if (m_ptr) m_adr[a[2:1]][15:8] = d; else m_adr[a[2:1]][7:0] = d; end
      end
      else if (a == 8)  m_cmd = d;
      else if (a == 9)  m_req[c] = d[2];
      else if (a == 10) m_mask[c] = d[2];
      else if (a == 11) m_mode[c] = d[7:2];
      else if (a == 14) m_mask = 4'h0;
      else if (a == 15) m_mask = d[3:0];
      else if (a == 13) begin m_mask = 4'hF; m_cmd = 0; m_req = 0; end
    end
    if ((w || r) && a < 8) m_ptr = !m_ptr;
    if (w && (a == 12 || a == 13)) m_ptr = 0;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    cmp_outs(w ? tag_of(a) : "R11");
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_adr[i] = 0; m_cnt[i] = 0; m_mode[i] = 0; end
    m_mask = 4'hF; m_req = 0; m_cmd = 0; m_ptr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk); cmp_outs("R1");
    // R2/R3: load channel 2 address, read back
    op(1, 0, 4'h4, 8'h34); op(1, 0, 4'h4, 8'h12);
    op(0, 1, 4'h4, 8'h00); op(0, 1, 4'h4, 8'h00);
    // R4: clear pointer mid-pair
    op(1, 0, 4'h3, 8'hAA); op(1, 0, 4'hC, 8'h00); op(1, 0, 4'h3, 8'h55);
    // R5, R10
    op(1, 0, 4'hE, 8'h00); op(1, 0, 4'hA, 8'h06); op(1, 0, 4'hA, 8'h02);
    op(1, 0, 4'hF, 8'h09);
    // R6: cascade + autoinit on channel 2
    op(1, 0, 4'hB, 8'hD2); op(1, 0, 4'hB, 8'h11);
    // R7, R8
    op(1, 0, 4'h8, 8'h5A); op(1, 0, 4'h9, 8'h07); op(0, 1, 4'h8, 8'h00);
    // R11
    op(0, 1, 4'hD, 8'h00); op(0, 1, 4'hF, 8'h00); op(0, 1, 4'h1, 8'h00);
    // R9 with pointer set
    op(1, 0, 4'h0, 8'h77); op(1, 0, 4'hD, 8'h00); op(0, 1, 4'h0, 8'h00);
    for (int k = 0; k < 3000; k++) begin
      bit w = $urandom_range(0, 2) != 0;
      op(w, !w, 4'($urandom_range(0, 15)), 8'($urandom));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule